// File: doc/BRIEF.md
# Dual-Tone Direct Digital Synthesizer

This block produces one 16-bit signed sample per enabled clock as the sum of two independently programmed sine tones. Each tone has its own phase accumulator, advanced by a programmable increment. It also has its own starting phase and a signed gain. The increment for a wanted output frequency is `f_out * 2^PHASE_W * clock_ratio / f_interface`, where `clock_ratio` relates the sample clock to the interface clock.

A single sync pulse restarts both tones together by loading each accumulator with its starting phase. The sine shape comes from a parabolic approximation computed in logic, so the block needs no stored table. Each tone sample is multiplied by its gain in 1.1.14 fixed point (sign bit, one integer bit, 14 fraction bits). The two scaled tones are added. The sum is clipped to the signed 16-bit range, so settings that over-drive the output, such as both gains at 0x4000, flatten at the rails and do not wrap. A valid flag marks each produced sample and follows the enable by a fixed three-cycle latency.

Top module: `dds_dual_tone`

## Requirements
- R1: While reset is held and after it is released with enable low, `valid_o` is 0 and `sample_o` is 0.
- R2: On a clock edge where `sync_i` is 1, tone 1's phase becomes `t1_init_i` and tone 2's phase becomes `t2_init_i` on that same edge, whatever `en_i` is. A sample taken on that edge still uses the phases held before the edge.
- R3: On an edge with `sync_i` 0 and `en_i` 1, each phase becomes (phase + increment) mod 2^PHASE_W. With both inputs 0, both phases hold.
- R4: The tone value for a phase uses the top 16 phase bits u. Let h = u[14:0] and y = floor(h*(32767-h)/8192). The tone is y when u[15] is 0 and -y when u[15] is 1.
- R5: Each scaled tone is floor(tone * gain / 16384), with gain read as a signed 16-bit 1.1.14 value. The output is the sum of the two scaled tones.
- R6: A sum above 32767 gives 32767, and a sum below -32768 gives -32768. With both phases at 0x4000 and both gains at 0x4000 the output is 32767. With both gains at 0xC000 it is -32768.
- R7: `valid_o` equals `en_i` as sampled three rising edges earlier. The sample made from the phases present at an enabled edge appears on `sample_o` together with that valid pulse.
- R8: While `valid_o` is 0, `sample_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Produce a sample and advance both phases |
| sync_i | input | 1 | Load both phases with their starting values |
| t1_incr_i | input | PHASE_W | Tone 1 phase increment |
| t1_init_i | input | PHASE_W | Tone 1 starting phase |
| t1_gain_i | input | 16 | Tone 1 gain, signed 1.1.14 |
| t2_incr_i | input | PHASE_W | Tone 2 phase increment |
| t2_init_i | input | PHASE_W | Tone 2 starting phase |
| t2_gain_i | input | 16 | Tone 2 gain, signed 1.1.14 |
| sample_o | output | 16 | Clipped sum of both scaled tones |
| valid_o | output | 1 | Marks a new sample on `sample_o` |

## Verification
The gain inputs are read two edges after the phase is sampled, so the checks assume each gain stays fixed while samples are in the pipeline. The stimulus changes gains only after three idle cycles have drained every sample. The phase and sign checks also assume that all inputs are synchronous to `clk` and that the reset synchronizer has settled. To respect this, the bench drives each new setting between clock edges and holds the enable low through the settling cycles. Sync pulses are issued both alone and while the enable is high, so that both the priority rule and the same-edge load are exercised.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int WAVE_W = 16;

  // Parabolic half-wave approximation of a sine over one phase cycle.
  function automatic logic signed [WAVE_W-1:0] wave_of(input logic [WAVE_W-1:0] u);
    logic [14:0] h;
    logic [29:0] p;
    logic [14:0] y;
    h = u[14:0];
    p = {15'd0, h} * {15'd0, 15'h7FFF - h};
    y = 15'(p >> 13);
    return u[15] ? -$signed({1'b0, y}) : $signed({1'b0, y});
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               sync_i,
  input  logic [PHASE_W-1:0] incr_i,
  input  logic [PHASE_W-1:0] init_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_d;
  logic               phase_ce;

  always_comb begin
    phase_ce = sync_i | en_i;
    if (sync_i) phase_d = init_i;
    else        phase_d = phase_o + incr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_o <= '0;
    else if (phase_ce) phase_o <= phase_d;
  end

endmodule

// File: rtl/dds_tone_shaper.sv
module dds_tone_shaper
  import dds_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wave_ce_i,
  input  logic                                          prod_ce_i,
  input  logic [PHASE_W-1:0]                            phase_i,
  input  logic signed [GAIN_W-1:0]                      gain_i,
  output logic signed [WAVE_W+GAIN_W-GAIN_FRAC-1:0]     prod_o
);

  localparam int FULL_W = WAVE_W + GAIN_W;
  localparam int PROD_W = FULL_W - GAIN_FRAC;

  logic signed [WAVE_W-1:0] wave_d, wave_q;
  logic signed [FULL_W-1:0] full_d;
  logic signed [PROD_W-1:0] prod_d;

  always_comb begin
    wave_d = wave_of(phase_i[PHASE_W-1 -: WAVE_W]);
    full_d = FULL_W'(wave_q) * FULL_W'(gain_i);
    prod_d = PROD_W'(full_d >>> GAIN_FRAC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wave_q <= '0;
    else if (wave_ce_i) wave_q <= wave_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prod_o <= '0;
    else if (prod_ce_i) prod_o <= prod_d;
  end

endmodule

// File: rtl/dds_dual_tone.sv
module dds_dual_tone
  import dds_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int OUT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     sync_i,
  input  logic [PHASE_W-1:0]       t1_incr_i,
  input  logic [PHASE_W-1:0]       t1_init_i,
  input  logic signed [GAIN_W-1:0] t1_gain_i,
  input  logic [PHASE_W-1:0]       t2_incr_i,
  input  logic [PHASE_W-1:0]       t2_init_i,
  input  logic signed [GAIN_W-1:0] t2_gain_i,
  output logic signed [OUT_W-1:0]  sample_o,
  output logic                     valid_o
);

  localparam int NTONE  = 2;
  localparam int PROD_W = WAVE_W + GAIN_W - GAIN_FRAC;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

  // Reset synchronizer: asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic [PHASE_W-1:0]       incr_w  [NTONE];
  logic [PHASE_W-1:0]       init_w  [NTONE];
  logic [PHASE_W-1:0]       phase_w [NTONE];
  logic signed [GAIN_W-1:0] gain_w  [NTONE];
  logic signed [PROD_W-1:0] prod_w  [NTONE];

  assign incr_w[0] = t1_incr_i;
  assign incr_w[1] = t2_incr_i;
  assign init_w[0] = t1_init_i;
  assign init_w[1] = t2_init_i;
  assign gain_w[0] = t1_gain_i;
  assign gain_w[1] = t2_gain_i;

  logic wave_vld_q, prod_vld_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wave_vld_q <= 1'b0;
      prod_vld_q <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      wave_vld_q <= en_i;
      prod_vld_q <= wave_vld_q;
      valid_o    <= prod_vld_q;
    end
  end

  for (genvar t = 0; t < NTONE; t++) begin : g_tone
    dds_phase_acc #(.PHASE_W(PHASE_W)) acc_i (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .en_i    (en_i),
      .sync_i  (sync_i),
      .incr_i  (incr_w[t]),
      .init_i  (init_w[t]),
      .phase_o (phase_w[t])
    );
    dds_tone_shaper #(.PHASE_W(PHASE_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) shp_i (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .wave_ce_i (en_i),
      .prod_ce_i (wave_vld_q),
      .phase_i   (phase_w[t]),
      .gain_i    (gain_w[t]),
      .prod_o    (prod_w[t])
    );
  end

  logic signed [SUM_W-1:0] sum_d, clip_d;
  logic signed [OUT_W-1:0] sample_d;

  always_comb begin
    sum_d = SUM_W'(prod_w[0]) + SUM_W'(prod_w[1]);
    if (sum_d > MAXV)      clip_d = MAXV;
    else if (sum_d < MINV) clip_d = MINV;
    else                   clip_d = sum_d;
    sample_d = clip_d[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        sample_o <= '0;
    else if (prod_vld_q) sample_o <= sample_d;
  end

endmodule

// File: rtl/dds_dual_tone_chk.sv
module dds_dual_tone_chk #(
  parameter int PHASE_W = 16,
  parameter int PROD_W  = 18,
  parameter int OUT_W   = 16
) (
  input logic                     clk,
  input logic                     rst_n_s,
  input logic                     en_i,
  input logic                     sync_i,
  input logic [PHASE_W-1:0]       t1_incr_i,
  input logic [PHASE_W-1:0]       t1_init_i,
  input logic [PHASE_W-1:0]       t2_incr_i,
  input logic [PHASE_W-1:0]       t2_init_i,
  input logic [PHASE_W-1:0]       phase1,
  input logic [PHASE_W-1:0]       phase2,
  input logic signed [PROD_W-1:0] prod1,
  input logic signed [PROD_W-1:0] prod2,
  input logic                     prod_vld,
  input logic signed [OUT_W-1:0]  sample_o,
  input logic                     valid_o
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)         age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n_s)
    (age_q == 2'd0) |-> (!valid_o && sample_o == '0));

  a_r2_sync_loads_both: assert property (@(posedge clk) disable iff (!rst_n_s)
    sync_i |=> (phase1 == $past(t1_init_i) && phase2 == $past(t2_init_i)));

  a_r3_phase_advance: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sync_i && en_i) |=> (phase1 == PHASE_W'($past(phase1) + $past(t1_incr_i)) &&
                           phase2 == PHASE_W'($past(phase2) + $past(t2_incr_i))));

  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sync_i && !en_i) |=> ($stable(phase1) && $stable(phase2)));

  a_r6_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n_s)
    (prod_vld && !prod1[PROD_W-1] && !prod2[PROD_W-1]) |=> !sample_o[OUT_W-1]);

  a_r6_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n_s)
    (prod_vld && prod1[PROD_W-1] && prod2[PROD_W-1]) |=> sample_o[OUT_W-1]);

  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n_s)
    (age_q == 2'd3) |-> (valid_o == $past(en_i, 3)));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !prod_vld |=> $stable(sample_o));

endmodule

bind dds_dual_tone dds_dual_tone_chk #(
  .PHASE_W (PHASE_W),
  .PROD_W  (PROD_W),
  .OUT_W   (OUT_W)
) chk_i (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .en_i      (en_i),
  .sync_i    (sync_i),
  .t1_incr_i (t1_incr_i),
  .t1_init_i (t1_init_i),
  .t2_incr_i (t2_incr_i),
  .t2_init_i (t2_init_i),
  .phase1    (phase_w[0]),
  .phase2    (phase_w[1]),
  .prod1     (prod_w[0]),
  .prod2     (prod_w[1]),
  .prod_vld  (prod_vld_q),
  .sample_o  (sample_o),
  .valid_o   (valid_o)
);

// File: tb/dds_dual_tone_tb_top.sv
module dds_dual_tone_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, sync;
  logic [15:0] inc1, init1, gain1, inc2, init2, gain2;
  logic signed [15:0] sample;
  logic        valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int expq[$];
  logic [2:0] vpipe = '0;
  logic [15:0] mp1 = '0, mp2 = '0;
  logic        have_last = 1'b0;
  logic [15:0] last_s;
  string       tag = "R4 R5";

  always #4 clk = ~clk;

  dds_dual_tone dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .sync_i(sync),
    .t1_incr_i(inc1), .t1_init_i(init1), .t1_gain_i(gain1),
    .t2_incr_i(inc2), .t2_init_i(init2), .t2_gain_i(gain2),
    .sample_o(sample), .valid_o(valid)
  );

  // inc1, init1, gain1, inc2, init2, gain2
  localparam logic [95:0] VEC [4] = '{
    {16'h0400, 16'h0000, 16'h4000, 16'h0000, 16'h0000, 16'h0000},
    {16'h1234, 16'h8000, 16'h2000, 16'h0A00, 16'h4000, 16'hE000},
    {16'hF000, 16'h3FFF, 16'h7FFF, 16'h0101, 16'hC000, 16'h8000},
    {16'h0800, 16'h0000, 16'h4000, 16'h0800, 16'h0000, 16'h4000}
  };

  function automatic int tone_ref(int p);
    int h, y;
    h = p & 32'h7FFF;
    y = (h * (32767 - h)) >>> 13;
    return ((p & 32'h8000) != 0) ? -y : y;
  endfunction

  function automatic int exp_ref(int p1, int p2, logic [15:0] g1, logic [15:0] g2);
    int s;
    s = ((tone_ref(p1) * int'($signed(g1))) >>> 14) + ((tone_ref(p2) * int'($signed(g2))) >>> 14);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (en) expq.push_back(exp_ref(int'(mp1), int'(mp2), gain1, gain2));
    if (sync) begin
      mp1 = init1; mp2 = init2;
    end else if (en) begin
      mp1 = mp1 + inc1; mp2 = mp2 + inc2;
    end
    vpipe = {vpipe[1:0], en};
    #2;
    check(valid == vpipe[2], "R7", int'(valid), int'(vpipe[2]));
    if (valid) begin
      if (expq.size() == 0) check(1'b0, "R7", int'(sample), 0);
      else begin
        int e;
        e = expq.pop_front();
        check(int'(sample) == e, tag, int'(sample), e);
      end
      last_s = sample; have_last = 1'b1;
    end else if (have_last) begin
      check(sample == last_s, "R8", int'(sample), int'($signed(last_s)));
    end
  endtask

  task automatic drain();
    en = 1'b0; sync = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check(expq.size() == 0, "R7", expq.size(), 0);
  endtask

  task automatic load(input logic [95:0] v);
    {inc1, init1, gain1, inc2, init2, gain2} = v;
    sync = 1'b1; en = 1'b0;
    tick();
    sync = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; sync = 1'b0;
    {inc1, init1, gain1, inc2, init2, gain2} = '0;
    repeat (3) @(posedge clk);
    #2;
    check(valid == 1'b0, "R1", int'(valid), 0);
    check(sample == 16'sd0, "R1", int'(sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    check(valid == 1'b0 && sample == 16'sd0, "R1", int'(sample), 0);

    // Table of settings, each run over a stream of samples.
    for (int v = 0; v < 4; v++) begin
      tag = (v >= 2) ? "R4 R5 R6" : "R4 R5";
      load(VEC[v]);
      en = 1'b1;
      for (int i = 0; i < 24; i++) tick();
      drain();
    end

    // R6: exact positive clip.
    tag = "R6";
    load({16'h0000, 16'h4000, 16'h4000, 16'h0000, 16'h4000, 16'h4000});
    en = 1'b1; tick();
    drain();
    check(sample == 16'sh7FFF, "R6", int'(sample), 32767);

    // R6: exact negative clip.
    load({16'h0000, 16'h4000, 16'hC000, 16'h0000, 16'h4000, 16'hC000});
    en = 1'b1; tick();
    drain();
    check(sample == -16'sd32768, "R6", int'(sample), -32768);

    // R2: sync while enabled restarts both tones on one edge; R3 hold across gaps.
    tag = "R2 R3";
    load({16'h0300, 16'h1000, 16'h3000, 16'h0700, 16'h2000, 16'h3000});
    en = 1'b1;
    for (int i = 0; i < 6; i++) tick();
    sync = 1'b1; tick();
    sync = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    en = 1'b0;
    for (int i = 0; i < 7; i++) tick();
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); en = ~en;
    end
    en = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    drain();

    // R8: long idle keeps the last sample.
    tag = "R8";
    for (int i = 0; i < 10; i++) tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule